// File: doc/BRIEF.md
# Shared-Counter Multi-Channel PWM Timer

This block produces several edge-aligned pulse-width-modulated outputs from one up-counter and one period value, both shared by every channel. Each channel compares the shared count against its own compare value and drives its pin according to its own mode and polarity field. Software reaches every setting through a simple 32-bit register bus: one write strobe, a byte address and write data, with read data returned combinationally for the address presented.

The counter advances once per prescaled tick, where the prescaler divides the clock by a power of two from 1 to 128. It counts from zero up to the period value and then returns to zero. That return marks the period boundary. While the counter runs, new period and compare values are held in shadow storage and become active only at the next boundary, so a period never mixes old and new settings. While the counter is stopped, the same writes take effect at once. Readback always shows the active value, so software can poll until a buffered update has landed. Changes to the output-level fields are not buffered and act on the next clock.

Top module: `shared_pwm_timer`

## Requirements
- R1: After reset every register reads 0, apart from the parameter register at 0x04, and every PWM output is low.
- R2: Address 0x04 always reads the channel count in bits [7:0]. Address 0x08 always reads 0. Writes to either address change nothing.
- R3: In the control register at 0x10, bits [2:0] hold the prescale exponent PS and bits [4:3] hold the counter mode. Bit 5 always reads 0. With mode 01 the counter advances once every 2^PS clocks, the first advance coming 2^PS clocks after the counter starts. With any other mode the counter holds its value.
- R4: The counter at 0x14 counts from 0 up to the active period (0x18) and returns to 0 on the next advance. Any write to 0x14 clears it to 0.
- R5: With mode 00, a write to the period register or to a compare register (0x24 + 8n) is active, and visible on readback, from the next clock.
- R6: With mode not 00, a period or compare write is held in a shadow register. Readback shows the old value until the next wrap of the counter to 0, and the new value from then on.
- R7: In channel control register 0x20 + 8n, bit 5 selects edge-aligned PWM, bit 4 is a second mode bit kept for readback, and bits [3:2] are the level field. With bit 5 = 1 and level 10, the output is high while count < compare. With bit 5 = 1 and level 01, the output is the complement of that. The output is registered, one clock behind the count.
- R8: With bit 5 = 0, or with level 00 or 11, the output is low. A change to the level field acts on the output one clock after the write, with no wait for a period boundary.
- R9: A compare value of 0 holds a normal-polarity output low for the whole period. A compare value above the period holds it high for the whole period.
- R10: Channel bit 7 is a flag. It is set while counting on any clock where count equals the channel's compare value. Writing 1 to it clears it, but a new match in the same clock wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | ADDR_W | Byte address for both reads and writes |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for bus_addr, combinational |
| pwm_out | output | NCH | One PWM output per channel |

## Verification
The bench goes after the boundary cases that a shared, shadowed counter makes easy to break.

- **Period write just before a wrap while running.** A design that applied it at once would show the new period early on readback and cut the running period short.
- **Prescale exponents other than zero.** Off-by-one tick placement moves the counter one clock early or late, and the per-clock comparison against the model catches that.
- **Compare of 0 and compare above the period.** A design that used `<=` instead of `<`, or clipped the compare value, would emit a one-count glitch or drop a pulse.
- **A flag clear while the counter is stopped.** A clear that did not stick would show up on readback.
- **Reserved level codes.** A design that decoded only one bit of the level field would drive a pulse where the pin must stay low.

// File: rtl/pwm_tmr_pkg.sv
package pwm_tmr_pkg;

  // Byte offsets of the register map
  localparam int unsigned OFS_PARAM   = 32'h04;
  localparam int unsigned OFS_GLOBAL  = 32'h08;
  localparam int unsigned OFS_CTRL    = 32'h10;
  localparam int unsigned OFS_COUNT   = 32'h14;
  localparam int unsigned OFS_PERIOD  = 32'h18;
  localparam int unsigned OFS_CH_BASE = 32'h20;
  localparam int unsigned CH_STRIDE   = 8;
  localparam int unsigned CH_CMP_OFS  = 4;

  // Counter mode field
  typedef enum logic [1:0] {
    CM_STOP = 2'b00,
    CM_INC  = 2'b01,
    CM_RSV2 = 2'b10,
    CM_RSV3 = 2'b11
  } cmode_e;

  // Channel output level field
  typedef enum logic [1:0] {
    LVL_OFF  = 2'b00,
    LVL_INV  = 2'b01,
    LVL_NORM = 2'b10,
    LVL_RSVD = 2'b11
  } lvl_e;

  // Channel control bit positions
  localparam int unsigned CHB_FLAG = 7;
  localparam int unsigned CHB_EDGE = 5;
  localparam int unsigned CHB_AUX  = 4;
  localparam int unsigned CHB_LVL  = 2;

  function automatic logic [7:0] pack_chctl(input logic flag, input logic edge_sel,
                                            input logic aux_sel, input lvl_e lvl);
    pack_chctl = {flag, 1'b0, edge_sel, aux_sel, lvl, 2'b00};
  endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned PS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic [PS_W-1:0] ps,
  output logic            tick
);
  localparam int unsigned DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] div_q, div_d, mask;

  always_comb begin
    mask = ~({DIV_W{1'b1}} << ps);
    tick = run && ((div_q & mask) == mask);
    div_d = run ? div_q + 1'b1 : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             immediate,
  input  logic             cnt_clr,
  input  logic             per_wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] per_act,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt_d, per_act_d, per_buf_q, per_buf_d;
  logic             pend_q, pend_d;

  assign wrap = tick && (cnt_q >= per_act);

  always_comb begin
    cnt_d     = cnt_q;
    per_act_d = per_act;
    per_buf_d = per_buf_q;
    pend_d    = pend_q;

    if (cnt_clr)   cnt_d = '0;
    else if (wrap) cnt_d = '0;
    else if (tick) cnt_d = cnt_q + 1'b1;

    if (wrap && pend_q) begin
      per_act_d = per_buf_q;
      pend_d    = 1'b0;
    end

    if (per_wr) begin
      if (immediate) begin
        per_act_d = wdata;
        pend_d    = 1'b0;
      end else begin
        per_buf_d = wdata;
        pend_d    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      per_act   <= '0;
      per_buf_q <= '0;
      pend_q    <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      per_act   <= per_act_d;
      per_buf_q <= per_buf_d;
      pend_q    <= pend_d;
    end
  end
endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic             cmp_wr,
  input  logic [7:0]       ctl_wdata,
  input  logic [CNT_W-1:0] cmp_wdata,
  input  logic             immediate,
  input  logic             wrap,
  input  logic             counting,
  input  logic [CNT_W-1:0] cnt,
  output logic [7:0]       ctl_rd,
  output logic [CNT_W-1:0] cmp_act,
  output logic             pwm_o
);
  logic             flag_q, flag_d;
  logic             edge_q, edge_d;
  logic             aux_q, aux_d;
  lvl_e             lvl_q, lvl_d;
  logic [CNT_W-1:0] cmp_act_d, cmp_buf_q, cmp_buf_d;
  logic             pend_q, pend_d;
  logic             out_d;
  logic             hit, below;

  assign hit    = counting && (cnt == cmp_act);
  assign below  = cnt < cmp_act;
  assign ctl_rd = pack_chctl(flag_q, edge_q, aux_q, lvl_q);

  always_comb begin
    flag_d    = flag_q;
    edge_d    = edge_q;
    aux_d     = aux_q;
    lvl_d     = lvl_q;
    cmp_act_d = cmp_act;
    cmp_buf_d = cmp_buf_q;
    pend_d    = pend_q;

    if (ctl_wr) begin
      edge_d = ctl_wdata[CHB_EDGE];
      aux_d  = ctl_wdata[CHB_AUX];
      lvl_d  = lvl_e'(ctl_wdata[CHB_LVL+1:CHB_LVL]);
      if (ctl_wdata[CHB_FLAG]) flag_d = 1'b0;
    end
    if (hit) flag_d = 1'b1;

    if (wrap && pend_q) begin
      cmp_act_d = cmp_buf_q;
      pend_d    = 1'b0;
    end
    if (cmp_wr) begin
      if (immediate) begin
        cmp_act_d = cmp_wdata;
        pend_d    = 1'b0;
      end else begin
        cmp_buf_d = cmp_wdata;
        pend_d    = 1'b1;
      end
    end

    out_d = 1'b0;
    if (edge_q) begin
      unique case (lvl_q)
        LVL_NORM: out_d = below;
        LVL_INV:  out_d = ~below;
        default:  out_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q    <= 1'b0;
      edge_q    <= 1'b0;
      aux_q     <= 1'b0;
      lvl_q     <= LVL_OFF;
      cmp_act   <= '0;
      cmp_buf_q <= '0;
      pend_q    <= 1'b0;
      pwm_o     <= 1'b0;
    end else begin
      flag_q    <= flag_d;
      edge_q    <= edge_d;
      aux_q     <= aux_d;
      lvl_q     <= lvl_d;
      cmp_act   <= cmp_act_d;
      cmp_buf_q <= cmp_buf_d;
      pend_q    <= pend_d;
      pwm_o     <= out_d;
    end
  end
endmodule

// File: rtl/shared_pwm_timer.sv
module shared_pwm_timer
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned PS_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    pwm_out
);
  localparam int unsigned CM_LSB = PS_W;

  // reset: asserted asynchronously, released after two clocks
  logic [1:0] rst_sync_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q = rst_sync_q[1];

  // address decode
  logic sel_param, sel_global, sel_ctrl, sel_count, sel_period;
  logic [NCH-1:0] sel_ch_ctl, sel_ch_cmp;
  assign sel_param  = bus_addr == ADDR_W'(OFS_PARAM);
  assign sel_global = bus_addr == ADDR_W'(OFS_GLOBAL);
  assign sel_ctrl   = bus_addr == ADDR_W'(OFS_CTRL);
  assign sel_count  = bus_addr == ADDR_W'(OFS_COUNT);
  assign sel_period = bus_addr == ADDR_W'(OFS_PERIOD);

  // global control register
  logic [PS_W-1:0] ps_q, ps_d;
  cmode_e          cmod_q, cmod_d;
  logic            counting, immediate;

  always_comb begin
    ps_d   = ps_q;
    cmod_d = cmod_q;
    if (bus_wr && sel_ctrl) begin
      ps_d   = bus_wdata[PS_W-1:0];
      cmod_d = cmode_e'(bus_wdata[CM_LSB+1:CM_LSB]);
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      ps_q   <= '0;
      cmod_q <= CM_STOP;
    end else begin
      ps_q   <= ps_d;
      cmod_q <= cmod_d;
    end
  end

  assign counting  = cmod_q == CM_INC;
  assign immediate = cmod_q == CM_STOP;

  // shared time base
  logic             tick, wrap;
  logic [CNT_W-1:0] cnt_q, per_act;

  pwm_prescaler #(.PS_W(PS_W)) u_psc (
    .clk  (clk),
    .rst_n(rst_q),
    .run  (counting),
    .ps   (ps_q),
    .tick (tick)
  );

  pwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_q),
    .tick     (tick),
    .immediate(immediate),
    .cnt_clr  (bus_wr && sel_count),
    .per_wr   (bus_wr && sel_period),
    .wdata    (bus_wdata[CNT_W-1:0]),
    .cnt_q    (cnt_q),
    .per_act  (per_act),
    .wrap     (wrap)
  );

  // channels
  logic [NCH-1:0][7:0]       ch_ctl_rd;
  logic [NCH-1:0][CNT_W-1:0] ch_cmp;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign sel_ch_ctl[g] = bus_addr == ADDR_W'(OFS_CH_BASE + CH_STRIDE * g);
    assign sel_ch_cmp[g] = bus_addr == ADDR_W'(OFS_CH_BASE + CH_STRIDE * g + CH_CMP_OFS);

    pwm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk      (clk),
      .rst_n    (rst_q),
      .ctl_wr   (bus_wr && sel_ch_ctl[g]),
      .cmp_wr   (bus_wr && sel_ch_cmp[g]),
      .ctl_wdata(bus_wdata[7:0]),
      .cmp_wdata(bus_wdata[CNT_W-1:0]),
      .immediate(immediate),
      .wrap     (wrap),
      .counting (counting),
      .cnt      (cnt_q),
      .ctl_rd   (ch_ctl_rd[g]),
      .cmp_act  (ch_cmp[g]),
      .pwm_o    (pwm_out[g])
    );
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (sel_param)       bus_rdata = DATA_W'(NCH[7:0]);
    else if (sel_global) bus_rdata = '0;
    else if (sel_ctrl)   bus_rdata = DATA_W'({cmod_q, ps_q});
    else if (sel_count)  bus_rdata = DATA_W'(cnt_q);
    else if (sel_period) bus_rdata = DATA_W'(per_act);
    for (int i = 0; i < NCH; i++) begin
      if (sel_ch_ctl[i]) bus_rdata = DATA_W'(ch_ctl_rd[i]);
      if (sel_ch_cmp[i]) bus_rdata = DATA_W'(ch_cmp[i]);
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata[DATA_W-1:CNT_W];
endmodule

// File: rtl/shared_pwm_timer_chk.sv
module shared_pwm_timer_chk
  import pwm_tmr_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input logic                      clk,
  input logic                      rst_q,
  input logic                      bus_wr,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [DATA_W-1:0]         bus_wdata,
  input logic [DATA_W-1:0]         bus_rdata,
  input logic [NCH-1:0]            pwm_out,
  input logic [CNT_W-1:0]          cnt_q,
  input logic [CNT_W-1:0]          per_act,
  input logic                      wrap,
  input logic                      counting,
  input logic                      immediate,
  input logic [NCH-1:0][7:0]       ch_ctl_rd,
  input logic [NCH-1:0][CNT_W-1:0] ch_cmp
);
  logic per_wr, cnt_wr;
  assign per_wr = bus_wr && (bus_addr == ADDR_W'(OFS_PERIOD));
  assign cnt_wr = bus_wr && (bus_addr == ADDR_W'(OFS_COUNT));

  // R2
  param_read_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_addr == ADDR_W'(OFS_PARAM)) |-> (bus_rdata == DATA_W'(NCH)));

  // R3
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (!counting && !cnt_wr) |=> $stable(cnt_q));

  // R4
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_q)
    wrap |=> (cnt_q == '0));

  // R5
  stop_period_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (per_wr && immediate) |=> (per_act == $past(bus_wdata[CNT_W-1:0])));

  // R6
  run_period_hold_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (per_wr && !immediate && !wrap) |=> $stable(per_act));

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R8
    out_gated_chk: assert property (@(posedge clk) disable iff (!rst_q)
      pwm_out[g] |-> $past(ch_ctl_rd[g][CHB_EDGE] &&
                           (ch_ctl_rd[g][CHB_LVL+1:CHB_LVL] == 2'b10 ||
                            ch_ctl_rd[g][CHB_LVL+1:CHB_LVL] == 2'b01)));
    // R10
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (counting && cnt_q == ch_cmp[g]) |=> ch_ctl_rd[g][CHB_FLAG]);
  end
endmodule

bind shared_pwm_timer shared_pwm_timer_chk #(
  .NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
  .clk      (clk),
  .rst_q    (rst_q),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata),
  .pwm_out  (pwm_out),
  .cnt_q    (cnt_q),
  .per_act  (per_act),
  .wrap     (wrap),
  .counting (counting),
  .immediate(immediate),
  .ch_ctl_rd(ch_ctl_rd),
  .ch_cmp   (ch_cmp)
);

// File: tb/shared_pwm_timer_test.sv
`timescale 1ns/1ps
module shared_pwm_timer_test;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] pwm_out;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string phase = "R1";

  shared_pwm_timer #(.NCH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  always #2 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  int m_ps, m_cmod, m_psc, m_cnt, m_per, m_pbuf;
  bit m_ppend;
  int m_cv[NCH], m_cbuf[NCH], m_ctl[NCH];
  bit m_cpend[NCH], m_flag[NCH], m_out[NCH];

  function automatic int m_read(input int a);
    if (a == 4)  return NCH;
    if (a == 16) return m_ps | (m_cmod << 3);
    if (a == 20) return m_cnt;
    if (a == 24) return m_per;
    if (a >= 32 && a < 32 + 8 * NCH) begin
      if ((a - 32) % 8 == 0) return (int'(m_flag[(a - 32) / 8]) << 7) | m_ctl[(a - 32) / 8];
      if ((a - 32) % 8 == 4) return m_cv[(a - 32) / 8];
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ps = 0; m_cmod = 0; m_psc = 0; m_cnt = 0; m_per = 0; m_pbuf = 0; m_ppend = 0;
      for (int i = 0; i < NCH; i++) begin
        m_cv[i] = 0; m_cbuf[i] = 0; m_ctl[i] = 0; m_cpend[i] = 0; m_flag[i] = 0; m_out[i] = 0;
      end
    end else begin
      automatic int a = bus_addr;
      automatic int d = bus_wdata;
      automatic bit w = bus_wr;
      automatic int mask = (1 << m_ps) - 1;
      automatic bit tick = (m_cmod == 1) && ((m_psc & mask) == mask);
      automatic bit wrp = tick && (m_cnt >= m_per);
      automatic bit stopped = (m_cmod == 0);
      automatic int old_cnt = m_cnt;
      for (int i = 0; i < NCH; i++) begin
        automatic bit raw = old_cnt < m_cv[i];
        automatic int lvl = (m_ctl[i] >> 2) & 3;
        automatic bit hit = (m_cmod == 1) && (old_cnt == m_cv[i]);
        automatic int ca = 32 + 8 * i;
        if (((m_ctl[i] >> 5) & 1) == 1 && lvl == 2)      m_out[i] = raw;
        else if (((m_ctl[i] >> 5) & 1) == 1 && lvl == 1) m_out[i] = !raw;
        else                                             m_out[i] = 0;
        if (w && a == ca) begin
          m_ctl[i] = d & 8'h3C;
          if (d[7]) m_flag[i] = 0;
        end
        if (hit) m_flag[i] = 1;
        if (wrp && m_cpend[i]) begin m_cv[i] = m_cbuf[i]; m_cpend[i] = 0; end
        if (w && a == ca + 4) begin
          if (stopped) begin m_cv[i] = d & 16'hFFFF; m_cpend[i] = 0; end
          else begin m_cbuf[i] = d & 16'hFFFF; m_cpend[i] = 1; end
        end
      end
      m_psc = (m_cmod == 1) ? ((m_psc + 1) & 127) : 0;
      if (w && a == 20) m_cnt = 0;
      else if (wrp)     m_cnt = 0;
      else if (tick)    m_cnt = m_cnt + 1;
      if (wrp && m_ppend) begin m_per = m_pbuf; m_ppend = 0; end
      if (w && a == 24) begin
        if (stopped) begin m_per = d & 16'hFFFF; m_ppend = 0; end
        else begin m_pbuf = d & 16'hFFFF; m_ppend = 1; end
      end
      if (w && a == 16) begin m_ps = d & 7; m_cmod = (d >> 3) & 3; end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    checks++;
    if (bus_rdata !== 32'(m_read(bus_addr))) begin
      errors++;
      $display("FAIL %s rdata addr=%h actual=%h expected=%h", phase, bus_addr, bus_rdata, m_read(bus_addr));
    end
    for (int i = 0; i < NCH; i++) begin
      if (pwm_out[i] !== m_out[i]) begin
        errors++;
        $display("FAIL %s pwm_out[%0d] actual=%b expected=%b", phase, i, pwm_out[i], m_out[i]);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      errors++;
      $display("FAIL %s watchdog actual=%0d cycles expected=<20000", phase, cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- tasks ----------------
  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a[7:0]; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic exp_rd(input int a, input int e, input string tag);
    bus_addr = a[7:0];
    #0.2;
    checks++;
    if (bus_rdata !== 32'(e)) begin
      errors++;
      $display("FAIL %s read %h actual=%h expected=%h", tag, a, bus_rdata, e);
    end
  endtask

  task automatic exp_out(input int ch, input bit e, input string tag);
    #0.2;
    checks++;
    if (pwm_out[ch] !== e) begin
      errors++;
      $display("FAIL %s pwm_out[%0d] actual=%b expected=%b", tag, ch, pwm_out[ch], e);
    end
  endtask

  // ---------------- stimulus ----------------
  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    idle(4);

    phase = "R1";
    exp_rd(16, 0, "R1"); exp_rd(20, 0, "R1"); exp_rd(24, 0, "R1");
    exp_rd(32, 0, "R1"); exp_rd(36, 0, "R1");
    checks++;
    if (pwm_out !== '0) begin errors++; $display("FAIL R1 pwm_out actual=%b expected=0", pwm_out); end

    phase = "R2";
    wr(4, 32'hFFFF_FFFF); wr(8, 32'h1234_5678);
    exp_rd(4, NCH, "R2"); exp_rd(8, 0, "R2");

    phase = "R5";
    wr(24, 9);  exp_rd(24, 9, "R5");
    wr(36, 3);  exp_rd(36, 3, "R5");
    wr(44, 6);  wr(52, 0); wr(60, 20);

    phase = "R7";
    wr(32, 32'h28);   // ch0 edge-aligned, normal
    wr(40, 32'h24);   // ch1 edge-aligned, inverted
    wr(48, 32'h28);   // ch2 normal, compare 0
    wr(56, 32'h38);   // ch3 normal, compare above period, aux bit set
    wr(16, 32'h08);   // run, ps 0
    idle(25);

    phase = "R9";
    exp_out(2, 1'b0, "R9"); exp_out(3, 1'b1, "R9");
    idle(7);
    exp_out(2, 1'b0, "R9"); exp_out(3, 1'b1, "R9");

    phase = "R6";
    wr(24, 5);   exp_rd(24, 9, "R6");
    wr(36, 2);   exp_rd(36, 3, "R6");
    idle(12);
    exp_rd(24, 5, "R6"); exp_rd(36, 2, "R6");
    idle(20);

    phase = "R8";
    wr(32, 32'h00); idle(1); exp_out(0, 1'b0, "R8");
    wr(32, 32'h2C); idle(1); exp_out(0, 1'b0, "R8");
    wr(32, 32'h08); idle(12);
    wr(32, 32'h28); idle(12);

    phase = "R4";
    wr(20, 32'hFFFF); idle(15);

    phase = "R10";
    wr(16, 0);
    exp_rd(32, 32'hA8, "R10");
    wr(32, 32'hA8);
    exp_rd(32, 32'h28, "R10");
    idle(3);
    exp_rd(32, 32'h28, "R10");

    phase = "R3";
    wr(20, 0); exp_rd(20, 0, "R4");
    wr(16, 32'h20); exp_rd(16, 0, "R3");
    wr(16, 32'h0A);
    idle(8);
    exp_rd(20, 2, "R3");
    idle(60);
    wr(16, 32'h0F);   // ps 7
    idle(300);
    wr(16, 32'h19);   // reserved mode, counter must hold
    idle(10);

    phase = "R5";
    wr(16, 0); wr(24, 3); exp_rd(24, 3, "R5");
    wr(16, 32'h08); idle(20);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule